// File: doc/BRIEF.md
# Dual-clock fall-through FIFO

This block is an elastic buffer between two clock domains. It holds 512 words of 18 bits in its memory. It has one more word in a registered output stage. The writer and the reader each run on their own free-running clock, and the two clocks may be unrelated or the very same net. The writer offers a word with two qualifier levels, and `in_rdy` tells it whether there is room. The reader never has to ask for the first word. When a word lands in an empty buffer, it moves into the output register by itself and `out_rdy` rises. The reader then takes each presented word by pulling its read enable and both output-enable qualifiers low.

Memory pointers cross between the domains as Gray code through two-flop synchronizers. Because of this, the room and data indications are always pessimistic, so nothing is lost or repeated. The write domain also exports `fill_level`, which counts words accepted but not yet taken by the reader. An external threshold unit can use it, and it also drives the half-full flag. The output-enable qualifiers produce a drive-enable signal in place of pad tri-state control. Reset is asynchronous, and it must be held while each clock makes at least four rising edges.

Top module: `fwft_fifo_2clk`

## Requirements
- R1: A word on `wr_data` is stored on a rising `wr_clk` edge if and only if `wr_qual_a` is 1, `wr_qual_b_n` is 0 and `in_rdy` is 1 at that edge. Any other combination stores nothing.
- R2: The presented word is taken on a rising `rd_clk` edge if and only if `rd_en_n`, `oe_a_n` and `oe_b_n` are all 0 and `out_rdy` is 1. `out_rdy` only falls after such an edge.
- R3: A word written into an empty buffer appears on `rd_data`, with `out_rdy` high, after the third rising `rd_clk` edge that follows the write edge. This holds whatever the read and output-enable levels are.
- R4: While `out_rdy` is 0, `rd_data` keeps the last word that was taken.
- R5: `in_rdy` is 0 while `rst_n` is low. It becomes 1 on the second rising `wr_clk` edge after `rst_n` is released.
- R6: While reset is asserted, `out_rdy`, `half_full` and `fill_level` are all 0.
- R7: With no reads, exactly 513 words are accepted (512 in memory plus the output register). After that `in_rdy` stays 0, and `fill_level` never exceeds 513.
- R8: Once both domains are quiet, `fill_level` equals words accepted minus words taken. `half_full` is 1 exactly when `fill_level` is 256 or more.
- R9: `rd_data_oe` is 1 exactly when `oe_a_n` and `oe_b_n` are both 0.
- R10: Words come out in the order they were accepted, with none lost or duplicated. This holds for identical clocks and for unrelated clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_clk | input | 1 | Write-side clock |
| wr_data | input | 18 | Word to store |
| wr_qual_a | input | 1 | Write qualifier, active high |
| wr_qual_b_n | input | 1 | Write qualifier, active low |
| in_rdy | output | 1 | Room available; low means full or in reset |
| half_full | output | 1 | Fill level at or above half the memory |
| fill_level | output | 10 | Words held, as seen from the write domain |
| rd_clk | input | 1 | Read-side clock |
| rd_en_n | input | 1 | Read enable, active low |
| oe_a_n | input | 1 | Output-enable qualifier, active low |
| oe_b_n | input | 1 | Output-enable qualifier, active low |
| out_rdy | output | 1 | `rd_data` holds a word not yet taken |
| rd_data | output | 18 | Registered output word |
| rd_data_oe | output | 1 | Drive enable for the output pads |

## Verification
A read pointer that is stuck or skips shows up at the very next qualified read. The word on `rd_data` no longer matches the head of the bench's reference queue, so the first wrong word flags it. A fault in the crossing or in the fall-through stage moves the cycle on which `out_rdy` rises away from the third read edge, and the identical-clock phase pins that cycle exactly. A wrong full or level calculation shows within a few write cycles after traffic stops. In that case the bench sees the count of accepted words differ from 513, or `fill_level` differ from the count it keeps itself.

// File: rtl/fwft_pkg.sv
package fwft_pkg;

  localparam int FWFT_DEF_DATA_W   = 18;
  localparam int FWFT_DEF_ADDR_W   = 9;
  localparam int FWFT_SYNC_STAGES  = 2;

  // Read-side qualifier bundle, all active low.
  typedef struct packed {
    logic rd_en_n;
    logic oe_a_n;
    logic oe_b_n;
  } fwft_rdq_t;

  // Write is requested when the high qualifier is set and the low one clear.
  function automatic logic fwft_wr_asked(input logic q_hi, input logic q_lo_n);
    return q_hi & ~q_lo_n;
  endfunction

  // A read is requested only when every read qualifier is low.
  function automatic logic fwft_rd_asked(input fwft_rdq_t q);
    return ~(q.rd_en_n | q.oe_a_n | q.oe_b_n);
  endfunction

  // Pads are driven only while both output-enable qualifiers are low.
  function automatic logic fwft_drive_on(input fwft_rdq_t q);
    return ~(q.oe_a_n | q.oe_b_n);
  endfunction

endpackage

// File: rtl/fwft_rst_sync.sv
module fwft_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= {chain[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/fwft_ptr_xing.sv
module fwft_ptr_xing #(
  parameter int PW     = 10,
  parameter int STAGES = 2
) (
  input  logic          src_clk,
  input  logic          src_rst_n,
  input  logic [PW-1:0] src_next,
  input  logic          dst_clk,
  input  logic          dst_rst_n,
  output logic [PW-1:0] dst_bin
);
  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Gray copy registered alongside the binary pointer (same edge, same value).
  logic [PW-1:0] src_gray;
  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) src_gray <= '0;
    else            src_gray <= to_gray(src_next);
  end

  logic [PW-1:0] stg [STAGES];
  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= src_gray;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dst_bin = from_gray(stg[STAGES-1]);
endmodule

// File: rtl/fwft_ram.sv
module fwft_ram #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 9
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  // Read address only moves past locations whose write has already crossed.
  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/fwft_wr_ctrl.sv
module fwft_wr_ctrl #(
  parameter int ADDR_W = 9,
  localparam int PW    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qual_a,
  input  logic              qual_b_n,
  input  logic [PW-1:0]     ram_rd_bin_s,
  input  logic [PW-1:0]     cons_bin_s,
  output logic [PW-1:0]     wr_next,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_we,
  output logic              in_rdy,
  output logic [PW-1:0]     fill_level,
  output logic              half_full
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DEPTH / 2;

  function automatic logic [PW-1:0] span(input logic [PW-1:0] lead,
                                          input logic [PW-1:0] trail);
    return lead - trail;
  endfunction

  logic [PW-1:0] wr_bin;
  logic          mem_full;

  assign mem_full   = (span(wr_bin, ram_rd_bin_s) == PW'(DEPTH));
  assign in_rdy     = rst_n & ~mem_full;
  assign wr_we      = fwft_pkg::fwft_wr_asked(qual_a, qual_b_n) & in_rdy;
  assign wr_next    = wr_bin + PW'(wr_we);
  assign wr_addr    = wr_bin[ADDR_W-1:0];
  assign fill_level = span(wr_bin, cons_bin_s);
  assign half_full  = (fill_level >= PW'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_bin <= '0;
    else        wr_bin <= wr_next;
  end
endmodule

// File: rtl/fwft_rd_ctrl.sv
module fwft_rd_ctrl #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 9,
  localparam int PW    = ADDR_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  fwft_pkg::fwft_rdq_t rdq,
  input  logic [PW-1:0]       wr_bin_s,
  input  logic [DATA_W-1:0]   ram_rdata,
  output logic [ADDR_W-1:0]   ram_raddr,
  output logic [PW-1:0]       ram_next,
  output logic [PW-1:0]       cons_next,
  output logic                out_rdy,
  output logic [DATA_W-1:0]   out_data,
  output logic                fire,
  output logic                load
);
  logic [PW-1:0] ram_bin;
  logic [PW-1:0] cons_bin;
  logic          ram_has;

  assign ram_has   = (wr_bin_s != ram_bin);
  assign fire      = out_rdy & fwft_pkg::fwft_rd_asked(rdq);
  // Refill the output stage when it is empty or being emptied this edge.
  assign load      = ram_has & (~out_rdy | fire);
  assign ram_next  = ram_bin + PW'(load);
  assign cons_next = cons_bin + PW'(fire);
  assign ram_raddr = ram_bin[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_bin  <= '0;
      cons_bin <= '0;
      out_rdy  <= 1'b0;
      out_data <= '0;
    end else begin
      ram_bin  <= ram_next;
      cons_bin <= cons_next;
      if (load) begin
        out_data <= ram_rdata;
        out_rdy  <= 1'b1;
      end else if (fire) begin
        out_rdy  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fwft_fifo_2clk.sv
module fwft_fifo_2clk #(
  parameter int DATA_W      = fwft_pkg::FWFT_DEF_DATA_W,
  parameter int ADDR_W      = fwft_pkg::FWFT_DEF_ADDR_W,
  parameter int SYNC_STAGES = fwft_pkg::FWFT_SYNC_STAGES,
  localparam int PW         = ADDR_W + 1
) (
  input  logic              rst_n,
  input  logic              wr_clk,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_qual_a,
  input  logic              wr_qual_b_n,
  output logic              in_rdy,
  output logic              half_full,
  output logic [PW-1:0]     fill_level,
  input  logic              rd_clk,
  input  logic              rd_en_n,
  input  logic              oe_a_n,
  input  logic              oe_b_n,
  output logic              out_rdy,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_data_oe
);
  logic wr_rst_n;
  logic rd_rst_n;

  fwft_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
    .clk(wr_clk), .arst_n(rst_n), .srst_n(wr_rst_n)
  );
  fwft_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
    .clk(rd_clk), .arst_n(rst_n), .srst_n(rd_rst_n)
  );

  // Named internal events (also observed by the bound checker).
  logic                wr_we;
  logic [ADDR_W-1:0]   wr_addr;
  logic [PW-1:0]       wr_next;
  logic [PW-1:0]       wr_bin_s;
  logic [PW-1:0]       ram_next;
  logic [PW-1:0]       ram_bin_s;
  logic [PW-1:0]       cons_next;
  logic [PW-1:0]       cons_bin_s;
  logic [ADDR_W-1:0]   ram_raddr;
  logic [DATA_W-1:0]   ram_rdata;
  logic                rd_fire;
  logic                rd_load;
  fwft_pkg::fwft_rdq_t rd_q;

  assign rd_q       = '{rd_en_n: rd_en_n, oe_a_n: oe_a_n, oe_b_n: oe_b_n};
  assign rd_data_oe = fwft_pkg::fwft_drive_on(rd_q);

  fwft_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n),
    .qual_a(wr_qual_a), .qual_b_n(wr_qual_b_n),
    .ram_rd_bin_s(ram_bin_s), .cons_bin_s(cons_bin_s),
    .wr_next(wr_next), .wr_addr(wr_addr), .wr_we(wr_we),
    .in_rdy(in_rdy), .fill_level(fill_level), .half_full(half_full)
  );

  fwft_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wr_clk(wr_clk), .wr_en(wr_we), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(ram_raddr), .rd_data(ram_rdata)
  );

  fwft_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .rdq(rd_q),
    .wr_bin_s(wr_bin_s), .ram_rdata(ram_rdata), .ram_raddr(ram_raddr),
    .ram_next(ram_next), .cons_next(cons_next),
    .out_rdy(out_rdy), .out_data(rd_data),
    .fire(rd_fire), .load(rd_load)
  );

  // Write pointer into the read domain.
  fwft_ptr_xing #(.PW(PW), .STAGES(SYNC_STAGES)) u_x_wr (
    .src_clk(wr_clk), .src_rst_n(wr_rst_n), .src_next(wr_next),
    .dst_clk(rd_clk), .dst_rst_n(rd_rst_n), .dst_bin(wr_bin_s)
  );
  // Memory read pointer into the write domain (room).
  fwft_ptr_xing #(.PW(PW), .STAGES(SYNC_STAGES)) u_x_ram (
    .src_clk(rd_clk), .src_rst_n(rd_rst_n), .src_next(ram_next),
    .dst_clk(wr_clk), .dst_rst_n(wr_rst_n), .dst_bin(ram_bin_s)
  );
  // Consumed-word pointer into the write domain (fill level).
  fwft_ptr_xing #(.PW(PW), .STAGES(SYNC_STAGES)) u_x_cons (
    .src_clk(rd_clk), .src_rst_n(rd_rst_n), .src_next(cons_next),
    .dst_clk(wr_clk), .dst_rst_n(wr_rst_n), .dst_bin(cons_bin_s)
  );
endmodule

// File: rtl/fwft_fifo_2clk_chk.sv
module fwft_fifo_2clk_chk #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 9,
  localparam int PW    = ADDR_W + 1
) (
  input logic              rst_n,
  input logic              wr_clk,
  input logic              wr_qual_a,
  input logic              wr_qual_b_n,
  input logic              in_rdy,
  input logic              half_full,
  input logic [PW-1:0]     fill_level,
  input logic              rd_clk,
  input logic              rd_en_n,
  input logic              oe_a_n,
  input logic              oe_b_n,
  input logic              out_rdy,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_load
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DEPTH / 2;

  // R1: without a qualified write the level can only stay or fall.
  p_wr_blocked_r1: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!wr_qual_a || wr_qual_b_n || !in_rdy) |=> (fill_level <= $past(fill_level)));

  // R8: the level never climbs by more than one word per write edge.
  p_fill_step_r8: assert property (@(posedge wr_clk) disable iff (!rst_n)
    1'b1 |=> (32'(fill_level) <= 32'($past(fill_level)) + 1));

  // R8: half-full can only switch on exactly at the threshold.
  p_hf_rise_r8: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $rose(half_full) |-> (32'(fill_level) == HALF));

  // R7: never more than memory plus output stage.
  p_no_overflow_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
    32'(fill_level) <= DEPTH + 1);

  // R7: at full capacity the writer is held off.
  p_full_blocks_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (32'(fill_level) == DEPTH + 1) |-> !in_rdy);

  // R4: output word only changes on a refill.
  p_hold_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_load |=> $stable(rd_data));

  // R2: ready only drops after a fully qualified read edge.
  p_ready_drop_r2: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $fell(out_rdy) |-> $past(!rd_en_n && !oe_a_n && !oe_b_n));

  // R5: no room reported during reset.
  p_in_rdy_reset_r5: assert property (@(posedge wr_clk)
    !rst_n |-> !in_rdy);

  // R6: read side and level report empty during reset.
  p_out_rdy_reset_r6: assert property (@(posedge rd_clk)
    !rst_n |-> (!out_rdy && !half_full && fill_level == '0));
endmodule

bind fwft_fifo_2clk fwft_fifo_2clk_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .rst_n(rst_n), .wr_clk(wr_clk), .wr_qual_a(wr_qual_a), .wr_qual_b_n(wr_qual_b_n),
  .in_rdy(in_rdy), .half_full(half_full), .fill_level(fill_level),
  .rd_clk(rd_clk), .rd_en_n(rd_en_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
  .out_rdy(out_rdy), .rd_data(rd_data), .rd_load(rd_load)
);

// File: tb/fwft_fifo_2clk_bench.sv
`timescale 1ns/1ps
module fwft_fifo_2clk_bench;
  localparam int DW   = 18;
  localparam int CAP  = 513;
  localparam int HALF = 256;

  logic          rst_n = 1'b0;
  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  bit            same_clk = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic          wr_qual_a = 1'b0;
  logic          wr_qual_b_n = 1'b1;
  logic          rd_en_n = 1'b1;
  logic          oe_a_n = 1'b1;
  logic          oe_b_n = 1'b1;
  logic          in_rdy, half_full, out_rdy, rd_data_oe;
  logic [9:0]    fill_level;
  logic [DW-1:0] rd_data;

  int vectors = 0;
  int miscompares = 0;
  logic [DW-1:0] ref_q[$];
  int wr_remaining = 0;
  int wr_pct = 0;
  int rd_pct = 0;
  int wr_acc = 0;
  logic [DW-1:0] word0;

  fwft_fifo_2clk u_fwft_fifo_2clk (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_data(wr_data),
    .wr_qual_a(wr_qual_a), .wr_qual_b_n(wr_qual_b_n), .in_rdy(in_rdy),
    .half_full(half_full), .fill_level(fill_level),
    .rd_clk(rd_clk), .rd_en_n(rd_en_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .out_rdy(out_rdy), .rd_data(rd_data), .rd_data_oe(rd_data_oe)
  );

  // 50 MHz write clock; read clock either follows it in the same process or runs free.
  always begin
    #10 wr_clk = ~wr_clk;
    if (same_clk) rd_clk = wr_clk;
  end
  always begin
    #13.5;
    if (!same_clk) rd_clk = ~rd_clk;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Write-side reference model: stimulus and queue push on the falling edge.
  always @(negedge wr_clk) begin
    if (!rst_n) begin
      wr_qual_a   = 1'b0;
      wr_qual_b_n = 1'b1;
    end else if (wr_remaining > 0 && int'($urandom_range(99)) < wr_pct) begin
      wr_qual_a   = 1'b1;
      wr_qual_b_n = 1'b0;
      wr_data     = DW'($urandom);
      if (in_rdy) begin
        ref_q.push_back(wr_data);
        wr_remaining--;
        wr_acc++;
      end
    end else begin
      case ($urandom_range(2))
        0:       begin wr_qual_a = 1'b0; wr_qual_b_n = 1'b0; end
        1:       begin wr_qual_a = 1'b1; wr_qual_b_n = 1'b1; end
        default: begin wr_qual_a = 1'b0; wr_qual_b_n = 1'b1; end
      endcase
      wr_data = DW'($urandom);
    end
  end

  // Read-side reference model: compare the word that the next edge takes.
  always @(negedge rd_clk) begin
    bit go;
    chk(rd_data_oe == (!oe_a_n && !oe_b_n), "R9 drive enable", rd_data_oe, !oe_a_n && !oe_b_n);
    go = rst_n && (int'($urandom_range(99)) < rd_pct);
    if (go) {rd_en_n, oe_a_n, oe_b_n} = 3'b000;
    else    {rd_en_n, oe_a_n, oe_b_n} = 3'($urandom_range(7, 1));
    if (go && out_rdy) begin
      if (ref_q.size() == 0) begin
        chk(1'b0, "R10 read with empty reference", 1, 0);
      end else begin
        logic [DW-1:0] exp;
        exp = ref_q.pop_front();
        chk(rd_data == exp, "R1/R2/R10 order", rd_data, exp);
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    wr_remaining = 0;
    rd_pct = 0;
    repeat (8) @(posedge wr_clk);
    #2;
    chk(in_rdy == 1'b0, "R5 in_rdy in reset", in_rdy, 0);
    chk(out_rdy == 1'b0, "R6 out_rdy in reset", out_rdy, 0);
    chk(half_full == 1'b0, "R6 half_full in reset", half_full, 0);
    chk(fill_level == 0, "R6 fill_level in reset", fill_level, 0);
    ref_q.delete();
    wr_acc = 0;
    @(negedge wr_clk);
    rst_n = 1'b1;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge wr_clk);
    #2;
  endtask

  task automatic run_stream(input int words, input int wp, input int rp);
    wr_pct = wp;
    rd_pct = rp;
    wr_remaining = words;
    wait (wr_remaining == 0);
    rd_pct = 100;
    wait (ref_q.size() == 0);
    settle(12);
    chk(fill_level == 0, "R8 level after stream", fill_level, 0);
    chk(out_rdy == 1'b0, "R10 nothing left over", out_rdy, 0);
  endtask

  initial begin
    // Phase A: one clock for both sides, exact latencies.
    same_clk = 1'b1;
    do_reset();
    @(posedge wr_clk); #2;
    chk(in_rdy == 1'b0, "R5 first edge after release", in_rdy, 0);
    @(posedge wr_clk); #2;
    chk(in_rdy == 1'b1, "R5 second edge after release", in_rdy, 1);

    // R3: single word falls through on the third read edge, reads disabled.
    rd_pct = 0;
    wr_pct = 100;
    wr_remaining = 1;
    wait (wr_remaining == 0);
    word0 = ref_q[0];
    @(posedge wr_clk);
    for (int k = 1; k <= 3; k++) begin
      @(posedge wr_clk); #2;
      if (k < 3) chk(out_rdy == 1'b0, "R3 ready too early", out_rdy, 0);
      else begin
        chk(out_rdy == 1'b1, "R3 ready on third edge", out_rdy, 1);
        chk(rd_data == word0, "R3 first word presented", rd_data, word0);
      end
    end

    // R4: take it, then the output holds it with ready low.
    rd_pct = 100;
    settle(6);
    chk(out_rdy == 1'b0, "R4 ready low after last read", out_rdy, 0);
    chk(rd_data == word0, "R4 last word held", rd_data, word0);
    settle(5);
    chk(rd_data == word0, "R4 still held", rd_data, word0);

    // R8: level and half-full around the threshold, no reads.
    rd_pct = 0;
    wr_remaining = HALF - 1;
    wait (wr_remaining == 0);
    settle(8);
    chk(fill_level == HALF - 1, "R8 level 255", fill_level, HALF - 1);
    chk(half_full == 1'b0, "R8 half_full below", half_full, 0);
    wr_remaining = 1;
    wait (wr_remaining == 0);
    settle(8);
    chk(fill_level == HALF, "R8 level 256", fill_level, HALF);
    chk(half_full == 1'b1, "R8 half_full at threshold", half_full, 1);

    // R7: keep pushing until blocked; capacity is 513.
    wr_remaining = 1000;
    settle(700);
    chk(ref_q.size() == CAP, "R7 accepted words", ref_q.size(), CAP);
    chk(fill_level == CAP, "R7 level at full", fill_level, CAP);
    chk(in_rdy == 1'b0, "R7 in_rdy at full", in_rdy, 0);
    wr_remaining = 0;

    // Drain in order and check the empty state.
    rd_pct = 100;
    wait (ref_q.size() == 0);
    settle(12);
    chk(fill_level == 0, "R8 level after drain", fill_level, 0);
    chk(half_full == 1'b0, "R8 half_full after drain", half_full, 0);
    chk(in_rdy == 1'b1, "R7 room after drain", in_rdy, 1);

    run_stream(400, 80, 60);

    // Phase B: unrelated read clock.
    same_clk = 1'b0;
    do_reset();
    settle(4);
    run_stream(2000, 70, 50);
    run_stream(1500, 100, 15);
    run_stream(1000, 25, 95);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #3000000;
    miscompares++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule